// File: doc/BRIEF.md
# Configuration Image Checker with Default Rebuild

This block validates a configuration image of 16-bit words held in a small local store, and replaces it with a known default image when the contents are not trustworthy. After a start pulse it fetches every word, one at a time and lowest address first, from an external serial EEPROM master over a simple request/ready handshake. It copies each word into the local store while keeping a running 16-bit sum and comparing the three marker slots near the end of the image against their fixed values.

The image is accepted when the sum of all words wraps to zero and all three markers match. Otherwise the block rewrites the whole local store with default contents. Every word below the marker slots becomes 0xFFFF, and the markers take their fixed values. The final word is the two's complement of the sum of all the words before it, so the rebuilt image sums to zero.

A one-cycle done pulse ends the run. From then on `status_bad` tells whether a rebuild took place, and a read port gives access to the final image. Writing a rebuilt image back to the EEPROM is left to other logic.

Top module: `nvimg_check_repair`

## Requirements
- R1: Fetches cover addresses 0 to N-1 in rising order, each exactly once per run. A new request is raised only after the previous one has been accepted (fetch_req and fetch_ready both high at a clock edge). The address of the next fetch is one above the previous one.
- R2: When the image is valid, status_bad is 0 at the done pulse and the read port returns every fetched word unchanged.
- R3: A nonzero 16-bit wrapping sum over all N fetched words makes status_bad 1.
- R4: A mismatch in any single marker slot makes status_bad 1, even when the sum is zero. The marker slots are word N-4 = 0x4646, word N-3 = 0x4442 and word N-2 = 0x444D.
- R5: After a rebuild, words 0 to N-5 read 0xFFFF and words N-4 to N-2 hold the three marker values.
- R6: After a rebuild, word N-1 holds the two's complement of the 16-bit sum of words 0 to N-2, so the image sums to zero.
- R7: done is high for exactly one cycle per run. status_bad holds its value from the done pulse until a later run reaches its verdict.
- R8: A start pulse that arrives while a run is in progress has no effect: no extra fetches and no extra done pulse.
- R9: After reset, fetch_req, done and status_bad are 0.
- R10: fetch_req and fetch_addr stay steady for as many cycles as the responder takes to raise fetch_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a check run |
| fetch_req | output | 1 | Word fetch request to the EEPROM master |
| fetch_addr | output | clog2(N_WORDS) | Word address of the pending fetch |
| fetch_ready | input | 1 | Fetch accepted; fetch_data is valid |
| fetch_data | input | 16 | Fetched word |
| done | output | 1 | One-cycle pulse at the end of a run |
| status_bad | output | 1 | 1 when the image was rebuilt |
| rd_addr | input | clog2(N_WORDS) | Read address into the final image |
| rd_data | output | 16 | Word at rd_addr (combinational when RD_REG = 0) |

## Verification
The bench builds the block with N_WORDS = 8 and RD_REG = 0. With these values the fill region is words 0 to 3, the markers sit at words 4 to 6 and the checksum is word 7, so each region of a rebuilt image can be inspected word by word on the read port. The short image keeps each run to a handful of cycles. That leaves room to fail each marker slot on its own, to run the responder with zero wait states and with several, and to pulse start again in the middle of a fetch sequence.

// File: rtl/nvimg_pkg.sv
package nvimg_pkg;

   localparam int WORD_W = 16;

   typedef logic [WORD_W-1:0] word_t;

   // Fixed marker values, ordered by slot position (N-4, N-3, N-2)
   localparam word_t MARK_LO  = 16'h4646;
   localparam word_t MARK_MID = 16'h4442;
   localparam word_t MARK_HI  = 16'h444D;
   localparam word_t FILL_VAL = 16'hFFFF;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_FETCH,
      PH_JUDGE,
      PH_FILL
   } phase_e;

   function automatic word_t marker_for(input int unsigned slot);
      case (slot)
         0:       return MARK_LO;
         1:       return MARK_MID;
         default: return MARK_HI;
      endcase
   endfunction

   function automatic word_t twos_neg(input word_t v);
      return (~v) + word_t'(1);
   endfunction

endpackage

// File: rtl/nvimg_store.sv
module nvimg_store
   import nvimg_pkg::*;
#(
   parameter int N_WORDS = 64,
   parameter int AW      = 6,
   parameter bit RD_REG  = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  word_t         wdata,
   input  logic [AW-1:0] raddr,
   output word_t         rdata
);

   word_t mem [N_WORDS];
   word_t rd_comb;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_comb begin
      if (int'(raddr) < N_WORDS) rd_comb = mem[raddr];
      else                       rd_comb = '0;
   end

   generate
      if (RD_REG) begin : g_rd_flop
         word_t rd_q;
         always_ff @(posedge clk) rd_q <= rd_comb;
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_comb;
      end
   endgenerate

endmodule

// File: rtl/nvimg_audit.sv
module nvimg_audit
   import nvimg_pkg::*;
#(
   parameter int N_WORDS = 64,
   parameter int AW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add_en,
   input  word_t         add_val,
   input  logic          chk_en,
   input  logic [AW-1:0] chk_addr,
   output word_t         sum,
   output logic          mark_bad
);

   localparam int N_MARK = 3;
   localparam int MARK_BASE = N_WORDS - 4;

   logic [N_MARK-1:0] mismatch;

   generate
      for (genvar k = 0; k < N_MARK; k++) begin : g_mark
         localparam logic [AW-1:0] SLOT = AW'(MARK_BASE + k);
         assign mismatch[k] = chk_en && (chk_addr == SLOT) &&
                              (add_val != marker_for(k));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum      <= '0;
         mark_bad <= 1'b0;
      end else if (clr) begin
         sum      <= '0;
         mark_bad <= 1'b0;
      end else begin
         if (add_en) sum <= sum + add_val;
         if (|mismatch) mark_bad <= 1'b1;
      end
   end

endmodule

// File: rtl/nvimg_seq.sv
module nvimg_seq
   import nvimg_pkg::*;
#(
   parameter int N_WORDS = 64,
   parameter int AW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          fetch_ready,
   input  word_t         fetch_data,
   input  word_t         sum,
   input  logic          mark_bad,
   output logic          fetch_req,
   output logic [AW-1:0] fetch_addr,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output word_t         ram_wdata,
   output logic          acc_clr,
   output logic          chk_en,
   output logic          done,
   output logic          status_bad
);

   localparam logic [AW-1:0] LAST     = AW'(N_WORDS - 1);
   localparam logic [AW-1:0] MARK0    = AW'(N_WORDS - 4);
   localparam logic [AW-1:0] MARK1    = AW'(N_WORDS - 3);
   localparam logic [AW-1:0] MARK2    = AW'(N_WORDS - 2);

   phase_e        phase;
   logic [AW-1:0] cursor;
   logic          xfer;
   logic          judge_bad;
   word_t         fill_word;

   always_comb begin
      if (cursor < MARK0)       fill_word = FILL_VAL;
      else if (cursor == MARK0) fill_word = MARK_LO;
      else if (cursor == MARK1) fill_word = MARK_MID;
      else if (cursor == MARK2) fill_word = MARK_HI;
      else                      fill_word = twos_neg(sum);
   end

   always_comb begin
      fetch_req  = (phase == PH_FETCH);
      fetch_addr = cursor;
      xfer       = fetch_req && fetch_ready;
      ram_we     = xfer || (phase == PH_FILL);
      ram_waddr  = cursor;
      ram_wdata  = (phase == PH_FILL) ? fill_word : fetch_data;
      chk_en     = xfer;
      acc_clr    = ((phase == PH_IDLE) && start) || (phase == PH_JUDGE);
      judge_bad  = (sum != '0) || mark_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cursor     <= '0;
         done       <= 1'b0;
         status_bad <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_FETCH;
                  cursor <= '0;
               end
            end
            PH_FETCH: begin
               if (xfer) begin
                  if (cursor == LAST) phase <= PH_JUDGE;
                  else                cursor <= cursor + 1'b1;
               end
            end
            PH_JUDGE: begin
               status_bad <= judge_bad;
               cursor     <= '0;
               if (judge_bad) begin
                  phase <= PH_FILL;
               end else begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            PH_FILL: begin
               if (cursor == LAST) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cursor <= cursor + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvimg_check_repair.sv
module nvimg_check_repair
   import nvimg_pkg::*;
#(
   parameter int  N_WORDS = 64,
   parameter bit  RD_REG  = 1'b0,
   localparam int AW      = $clog2(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              fetch_req,
   output logic [AW-1:0]     fetch_addr,
   input  logic              fetch_ready,
   input  logic [WORD_W-1:0] fetch_data,
   output logic              done,
   output logic              status_bad,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   generate
      if (N_WORDS < 5) begin : g_param_err
         $error("nvimg_check_repair: N_WORDS must be at least 5");
      end
   endgenerate

   logic          ram_we;
   logic [AW-1:0] ram_waddr;
   word_t         ram_wdata;
   logic          acc_clr;
   logic          chk_en;
   word_t         sum;
   logic          mark_bad;

   nvimg_seq #(.N_WORDS(N_WORDS), .AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .fetch_ready(fetch_ready),
      .fetch_data (fetch_data),
      .sum        (sum),
      .mark_bad   (mark_bad),
      .fetch_req  (fetch_req),
      .fetch_addr (fetch_addr),
      .ram_we     (ram_we),
      .ram_waddr  (ram_waddr),
      .ram_wdata  (ram_wdata),
      .acc_clr    (acc_clr),
      .chk_en     (chk_en),
      .done       (done),
      .status_bad (status_bad)
   );

   nvimg_audit #(.N_WORDS(N_WORDS), .AW(AW)) u_audit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr),
      .add_en  (ram_we),
      .add_val (ram_wdata),
      .chk_en  (chk_en),
      .chk_addr(ram_waddr),
      .sum     (sum),
      .mark_bad(mark_bad)
   );

   nvimg_store #(.N_WORDS(N_WORDS), .AW(AW), .RD_REG(RD_REG)) u_store (
      .clk  (clk),
      .we   (ram_we),
      .waddr(ram_waddr),
      .wdata(ram_wdata),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

endmodule

// File: rtl/nvimg_check_repair_chk.sv
module nvimg_check_repair_chk #(
   parameter int N_WORDS = 64
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic                         fetch_req,
   input logic [$clog2(N_WORDS)-1:0]   fetch_addr,
   input logic                         fetch_ready,
   input logic                         done,
   input logic                         status_bad
);

   localparam int AW = $clog2(N_WORDS);
   localparam logic [AW-1:0] LAST = AW'(N_WORDS - 1);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ready) |=> (fetch_req && $stable(fetch_addr)));

   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ready && fetch_addr != LAST) |=>
         (fetch_req && fetch_addr == $past(fetch_addr) + AW'(1)));

   // R1
   last_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ready && fetch_addr == LAST) |=> !fetch_req);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !fetch_req);

   // R7
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fetch_req || (!start && !fetch_req && !done && $stable(fetch_req)
         && status_bad == $past(status_bad))) |=> $stable(status_bad)
         or !$stable(fetch_req));

   // R9
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!fetch_req && !done && !status_bad));

endmodule

bind nvimg_check_repair nvimg_check_repair_chk #(.N_WORDS(N_WORDS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .fetch_req  (fetch_req),
   .fetch_addr (fetch_addr),
   .fetch_ready(fetch_ready),
   .done       (done),
   .status_bad (status_bad)
);

// File: tb/nvimg_check_repair_bench.sv
module nvimg_check_repair_bench;

   localparam int N  = 8;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic          fetch_ready = 1'b0;
   logic [15:0]   fetch_data = '0;
   logic          done;
   logic          status_bad;
   logic [AW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;

   int vectors = 0;
   int fails   = 0;

   logic [15:0] eep [N];
   logic [15:0] expct [N];
   int lat = 0;
   int waitc = 0;
   int xfer_cnt = 0;
   int exp_next = 0;
   int order_err = 0;
   int done_cnt = 0;

   always #10 clk = ~clk;

   nvimg_check_repair #(.N_WORDS(N), .RD_REG(1'b0)) u_nvimg_check_repair (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_ready(fetch_ready), .fetch_data(fetch_data),
      .done(done), .status_bad(status_bad),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // EEPROM responder with a programmable wait
   always @(negedge clk) begin
      if (fetch_req) begin
         if (waitc >= lat) begin
            fetch_ready = 1'b1;
            fetch_data  = eep[fetch_addr];
            waitc = 0;
         end else begin
            fetch_ready = 1'b0;
            waitc++;
         end
      end else begin
         fetch_ready = 1'b0;
         waitc = 0;
      end
   end

   always @(posedge clk) begin
      if (fetch_req && fetch_ready) begin
         if (int'(fetch_addr) != exp_next) order_err++;
         exp_next++;
         xfer_cnt++;
      end
      if (done) done_cnt++;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sum_upto(input int last);
      logic [15:0] s = '0;
      for (int i = 0; i <= last; i++) s = s + eep[i];
      return s;
   endfunction

   task automatic make_good(input logic [15:0] seed);
      for (int i = 0; i < N - 4; i++) eep[i] = seed + 16'(i * 16'h1357);
      eep[N-4] = 16'h4646;
      eep[N-3] = 16'h4442;
      eep[N-2] = 16'h444D;
      eep[N-1] = '0;
      eep[N-1] = (~sum_upto(N - 2)) + 16'd1;
   endtask

   task automatic make_defaults();
      logic [15:0] s = '0;
      for (int i = 0; i < N - 4; i++) expct[i] = 16'hFFFF;
      expct[N-4] = 16'h4646;
      expct[N-3] = 16'h4442;
      expct[N-2] = 16'h444D;
      for (int i = 0; i < N - 1; i++) s = s + expct[i];
      expct[N-1] = (~s) + 16'd1;
   endtask

   task automatic run_once();
      xfer_cnt = 0; exp_next = 0; order_err = 0; done_cnt = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 2000; c++) begin
         if (done) break;
         @(negedge clk);
      end
      check(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic read_compare(input string req);
      for (int i = 0; i < N; i++) begin
         rd_addr = AW'(i);
         #1;
         check(rd_data == expct[i], req, 32'(rd_data), 32'(expct[i]));
      end
   endtask

   task automatic t_reset();
      check(fetch_req == 1'b0, "R9 req after reset", 32'(fetch_req), 0);
      check(done == 1'b0, "R9 done after reset", 32'(done), 0);
      check(status_bad == 1'b0, "R9 status after reset", 32'(status_bad), 0);
   endtask

   task automatic t_good(input int wait_states, input logic [15:0] seed);
      lat = wait_states;
      make_good(seed);
      for (int i = 0; i < N; i++) expct[i] = eep[i];
      run_once();
      check(status_bad == 1'b0, "R2 good verdict", 32'(status_bad), 0);
      check(xfer_cnt == N, "R1 fetch count", 32'(xfer_cnt), 32'(N));
      check(order_err == 0, "R1 fetch order", 32'(order_err), 0);
      check(done_cnt == 1, "R7 single done", 32'(done_cnt), 1);
      read_compare(wait_states > 0 ? "R10 image kept with waits" : "R2 image kept");
   endtask

   task automatic t_bad_sum();
      lat = 1;
      make_good(16'h0A0A);
      eep[2] = eep[2] ^ 16'h0040;
      make_defaults();
      run_once();
      check(status_bad == 1'b1, "R3 sum verdict", 32'(status_bad), 1);
      read_compare("R5 R6 rebuilt image");
      begin
         logic [15:0] s = '0;
         for (int i = 0; i < N; i++) begin
            rd_addr = AW'(i); #1; s = s + rd_data;
         end
         check(s == 16'd0, "R6 rebuilt image sums to zero", 32'(s), 0);
      end
      repeat (10) @(negedge clk);
      check(status_bad == 1'b1, "R7 status held", 32'(status_bad), 1);
   endtask

   task automatic t_bad_marker(input int slot);
      lat = 0;
      make_good(16'h2222 + 16'(slot));
      eep[N-4+slot] = 16'h1234;
      eep[N-1] = '0;
      eep[N-1] = (~sum_upto(N - 2)) + 16'd1;
      make_defaults();
      run_once();
      check(status_bad == 1'b1, "R4 marker verdict", 32'(status_bad), 1);
      rd_addr = AW'(N - 4 + slot); #1;
      check(rd_data == expct[N-4+slot], "R5 marker restored", 32'(rd_data),
            32'(expct[N-4+slot]));
   endtask

   task automatic t_busy_start();
      lat = 2;
      make_good(16'h5151);
      xfer_cnt = 0; exp_next = 0; order_err = 0; done_cnt = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      check(done_cnt == 1, "R8 extra start no extra done", 32'(done_cnt), 1);
      check(xfer_cnt == N, "R8 extra start no extra fetch", 32'(xfer_cnt), 32'(N));
      check(order_err == 0, "R1 order under extra start", 32'(order_err), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good(0, 16'h1111);
      t_good(3, 16'hBEEF);
      t_bad_sum();
      t_good(0, 16'h0C0C);
      for (int k = 0; k < 3; k++) t_bad_marker(k);
      t_busy_start();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule